// File: doc/BRIEF.md
# Host Receive Pipe Controller

This block is the receive side of one pipe in a USB host controller. It decides when to issue IN requests toward a device, and it holds the returned packets in a ring of one to three receive banks. Firmware drains those banks through a byte read port. The actual packet exchange is done by a separate packet engine. Here that engine appears as a token request/acknowledge pair plus a byte stream that carries a last-byte marker.

Request generation is controlled through a freeze bit. While the pipe is frozen, nothing is requested. Clearing the freeze starts requests at once. In counted mode the pipe issues a preset number of requests plus one and then freezes itself. In endless mode it keeps requesting until firmware freezes it. Requests only go out when a bank is free to receive the answer.

Each bank has an ownership flag (the FIFO control flag) and the pipe has a received-data flag. Both rise together when the bank under the read port becomes full. Firmware must acknowledge the received-data flag first and release the bank second. A release moves the read port on to the next bank in the ring.

Top module: `hin_pipe_ctrl`

## Requirements
- R1: After reset the pipe is frozen, and tok_req, rx_flag, fifo_ctl, irq and rd_allowed are all 0.
- R2: While frozen, tok_req stays 0. One cycle after a freeze_clr pulse on a frozen pipe, tok_req is 1, provided a bank is free. A freeze_set pulse brings tok_req back to 0 in the following cycle.
- R3: With req_endless=0, the pipe accepts exactly req_count+1 request handshakes (tok_req and tok_ack both 1 in a cycle) and is frozen from the cycle after the last one. req_count is captured when freeze_clr unfreezes the pipe.
- R4: With req_endless=1, the pipe stays unfrozen and issues a new request whenever a bank is free and no packet is outstanding.
- R5: When the bank under the read port becomes full, rx_flag and fifo_ctl both become 1 in the same cycle. A bank becomes full on a byte with pkt_last=1. irq equals rx_flag AND irq_en.
- R6: A irq_ack pulse clears rx_flag. It leaves fifo_ctl, rd_allowed and rd_data unchanged.
- R7: A bank_release pulse with rx_flag=0 and fifo_ctl=1 frees the current bank and moves to the next bank in the ring. If that bank already holds a packet, rx_flag and fifo_ctl are both 1 in the next cycle; otherwise both are 0.
- R8: A bank_release pulse while rx_flag=1 is ignored: fifo_ctl stays 1 and rd_data is unchanged.
- R9: rd_allowed is 1 while the current bank is owned and still holds unread bytes. Reading the last byte drops rd_allowed to 0 and leaves fifo_ctl at 1.
- R10: While every bank is full, tok_req stays 0 and no request is counted. A request resumes in the cycle after a release frees a bank.
- R11: Bytes are read back in arrival order. The read position restarts at byte 0 every time a bank becomes current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freeze_set | input | 1 | Pulse: freeze the pipe |
| freeze_clr | input | 1 | Pulse: unfreeze the pipe and capture req_count |
| req_endless | input | 1 | 1 = endless requests, 0 = counted requests |
| req_count | input | REQ_W | Number of counted requests minus one |
| irq_en | input | 1 | Enable of the pipe interrupt |
| irq_ack | input | 1 | Pulse: clear rx_flag |
| bank_release | input | 1 | Pulse: hand the current bank back |
| tok_req | output | 1 | IN request toward the packet engine |
| tok_ack | input | 1 | Packet engine takes the request |
| pkt_valid | input | 1 | Received byte valid |
| pkt_data | input | 8 | Received byte |
| pkt_last | input | 1 | Last byte of the packet |
| pkt_ready | output | 1 | A request is outstanding and bytes are accepted |
| rd_en | input | 1 | Pulse: advance the read position |
| rd_data | output | 8 | Byte at the read position |
| rd_allowed | output | 1 | Unread data remains in the current bank |
| frozen | output | 1 | Freeze status |
| rx_flag | output | 1 | Received-data flag |
| fifo_ctl | output | 1 | Current bank is owned by firmware |
| irq | output | 1 | Pipe interrupt |

## Verification
The hardest state to reach is a ring in which every bank is full while the pipe is unfrozen in endless mode. A counted run of two requests fills both banks and leaves the pipe frozen. The bench then unfreezes it in endless mode and watches tok_req stay low. It releases one bank and watches the request come back. The same full ring is also used to try a release while rx_flag is still set. Finally it shows that a release onto a bank that is already full raises both flags again at once.

// File: rtl/hin_pipe_pkg.sv
package hin_pipe_pkg;
  typedef logic [7:0] hin_byte_t;

  // next index in a ring of n entries
  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/hin_req_ctl.sv
module hin_req_ctl #(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_set,
  input  logic             freeze_clr,
  input  logic             req_endless,
  input  logic [REQ_W-1:0] req_count,
  input  logic             tok_ack,
  input  logic             bank_free,
  input  logic             pkt_done,
  output logic             tok_req,
  output logic             frozen,
  output logic             pkt_ready
);
  logic             frozen_q, frozen_d;
  logic             outst_q, outst_d;
  logic [REQ_W-1:0] remain_q, remain_d;
  logic             hs, last_req, reload;

  always_comb begin
    tok_req  = !frozen_q && !outst_q && bank_free;
    hs       = tok_req && tok_ack;
    last_req = hs && !req_endless && (remain_q == '0);
    reload   = frozen_q && freeze_clr && !freeze_set;

    frozen_d = frozen_q;
    if (freeze_set)      frozen_d = 1'b1;
    else if (freeze_clr) frozen_d = 1'b0;
    else if (last_req)   frozen_d = 1'b1;

    remain_d = remain_q;
    if (reload)                                        remain_d = req_count;
    else if (hs && !req_endless && remain_q != '0)     remain_d = remain_q - 1'b1;

    outst_d = outst_q;
    if (hs)            outst_d = 1'b1;
    else if (pkt_done) outst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b1;
      outst_q  <= 1'b0;
      remain_q <= '0;
    end else begin
      frozen_q <= frozen_d;
      outst_q  <= outst_d;
      remain_q <= remain_d;
    end
  end

  assign frozen    = frozen_q;
  assign pkt_ready = outst_q;

  // R3
  counted_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_req && !freeze_clr |=> frozen_q);

  // R4
  endless_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && req_endless && !freeze_set |=> !frozen_q);
endmodule

// File: rtl/hin_bank_store.sv
module hin_bank_store
  import hin_pipe_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_valid,
  input  hin_byte_t wr_data,
  input  logic      wr_last,
  input  logic      rel_go,
  input  logic      rd_en,
  output hin_byte_t rd_data,
  output logic      rd_allowed,
  output logic      cur_full,
  output logic      wr_free,
  output logic      cur_fill_evt
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
  localparam int CNT_W  = $clog2(BANK_BYTES + 1);

  hin_byte_t              mem_q [NUM_BANKS][BANK_BYTES];
  logic [CNT_W-1:0]       cnt_q [NUM_BANKS];
  logic [NUM_BANKS-1:0]   full_q, full_d;
  logic [BANK_W-1:0]      cur_q, cur_d, wr_bank_q, wr_bank_d;
  logic [CNT_W-1:0]       wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wr_len;
  logic                   wr_end, wr_keep, rd_step;

  always_comb begin
    wr_end  = wr_valid && wr_last;
    wr_keep = wr_valid && (wr_ptr_q < CNT_W'(BANK_BYTES));
    wr_len  = wr_keep ? wr_ptr_q + 1'b1 : wr_ptr_q;

    full_d = full_q;
    if (rel_go) full_d[cur_q]     = 1'b0;
    if (wr_end) full_d[wr_bank_q] = 1'b1;

    cur_d     = rel_go ? BANK_W'(ring_next(32'(cur_q), NUM_BANKS)) : cur_q;
    wr_bank_d = wr_end ? BANK_W'(ring_next(32'(wr_bank_q), NUM_BANKS)) : wr_bank_q;

    // the bank under the read port turns full: by arrival or by moving on
    cur_fill_evt = full_d[cur_d] && (rel_go || !full_q[cur_q]);

    cur_full   = full_q[cur_q];
    rd_allowed = cur_full && (rd_ptr_q < cnt_q[cur_q]);
    rd_step    = rd_en && rd_allowed;
    rd_data    = mem_q[cur_q][rd_ptr_q[ADDR_W-1:0]];
    wr_free    = !full_q[wr_bank_q];

    wr_ptr_d = wr_ptr_q;
    if (wr_end)       wr_ptr_d = '0;
    else if (wr_keep) wr_ptr_d = wr_ptr_q + 1'b1;

    rd_ptr_d = rd_ptr_q;
    if (rel_go)       rd_ptr_d = '0;
    else if (rd_step) rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      cur_q     <= '0;
      wr_bank_q <= '0;
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
    end else begin
      full_q    <= full_d;
      cur_q     <= cur_d;
      wr_bank_q <= wr_bank_d;
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_keep) mem_q[wr_bank_q][wr_ptr_q[ADDR_W-1:0]] <= wr_data;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_end && wr_bank_q == BANK_W'(b)) cnt_q[b] <= wr_len;
    end
  end

  // R10
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !full_q[wr_bank_q]);

  // R9
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step && (rd_ptr_q + 1'b1 == cnt_q[cur_q]) && !rel_go |=> cur_full && !rd_allowed);

  // R11
  rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_go |=> rd_ptr_q == '0);
endmodule

// File: rtl/hin_pipe_ctrl.sv
module hin_pipe_ctrl
  import hin_pipe_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  parameter int REQ_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_set,
  input  logic             freeze_clr,
  input  logic             req_endless,
  input  logic [REQ_W-1:0] req_count,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             bank_release,
  output logic             tok_req,
  input  logic             tok_ack,
  input  logic             pkt_valid,
  input  logic [7:0]       pkt_data,
  input  logic             pkt_last,
  output logic             pkt_ready,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_allowed,
  output logic             frozen,
  output logic             rx_flag,
  output logic             fifo_ctl,
  output logic             irq
);
  logic rx_q, rx_d;
  logic cur_full, wr_free, fill_evt, rel_go, wr_valid;

  assign wr_valid = pkt_valid && pkt_ready;
  assign rel_go   = bank_release && !rx_q && cur_full;

  hin_req_ctl #(.REQ_W(REQ_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_set (freeze_set),
    .freeze_clr (freeze_clr),
    .req_endless(req_endless),
    .req_count  (req_count),
    .tok_ack    (tok_ack),
    .bank_free  (wr_free),
    .pkt_done   (wr_valid && pkt_last),
    .tok_req    (tok_req),
    .frozen     (frozen),
    .pkt_ready  (pkt_ready)
  );

  hin_bank_store #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_data     (pkt_data),
    .wr_last     (pkt_last),
    .rel_go      (rel_go),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_allowed  (rd_allowed),
    .cur_full    (cur_full),
    .wr_free     (wr_free),
    .cur_fill_evt(fill_evt)
  );

  always_comb begin
    rx_d = rx_q;
    if (fill_evt)     rx_d = 1'b1;
    else if (irq_ack) rx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_d;
  end

  assign rx_flag  = rx_q;
  assign fifo_ctl = cur_full;
  assign irq      = rx_q && irq_en;

  // R5
  rx_with_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_q) |-> cur_full);

  // R8
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_release && rx_q |=> cur_full && $stable(rd_data));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !fill_evt |=> !rx_q);
endmodule

// File: tb/hin_pipe_ctrl_tb.sv
module hin_pipe_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze_set = 0, freeze_clr = 0, req_endless = 0, irq_en = 0, irq_ack = 0;
  logic bank_release = 0, tok_ack = 0, pkt_valid = 0, pkt_last = 0, rd_en = 0;
  logic [7:0] req_count = '0, pkt_data = '0;
  logic tok_req, pkt_ready, rd_allowed, frozen, rx_flag, fifo_ctl, irq;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hin_pipe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .freeze_set(freeze_set), .freeze_clr(freeze_clr),
    .req_endless(req_endless), .req_count(req_count), .irq_en(irq_en), .irq_ack(irq_ack),
    .bank_release(bank_release), .tok_req(tok_req), .tok_ack(tok_ack),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_ready(pkt_ready),
    .rd_en(rd_en), .rd_data(rd_data), .rd_allowed(rd_allowed), .frozen(frozen),
    .rx_flag(rx_flag), .fifo_ctl(fifo_ctl), .irq(irq)
  );

  // packets: {length[6:0], first byte[7:0]}; byte i = first + i
  localparam logic [14:0] VEC [4] = '{
    {7'd1, 8'h11}, {7'd4, 8'hA0}, {7'd64, 8'h3C}, {7'd2, 8'hF0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_release();
    bank_release = 1; tick(); bank_release = 0;
  endtask
  task automatic pulse_ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask
  task automatic pulse_clr();
    freeze_clr = 1; tick(); freeze_clr = 0;
  endtask

  task automatic handshake(string req);
    int n = 0;
    while (!tok_req && n < 20) begin tick(); n++; end
    chk(req, "tok_req before handshake", 32'(tok_req), 1);
    tok_ack = 1; tick(); tok_ack = 0;
  endtask

  task automatic send_pkt(int len, logic [7:0] first);
    for (int i = 0; i < len; i++) begin
      pkt_valid = 1; pkt_data = first + 8'(i); pkt_last = (i == len - 1);
      tick();
    end
    pkt_valid = 0; pkt_last = 0;
  endtask

  task automatic drain(string req, int len, logic [7:0] first);
    for (int i = 0; i < len; i++) begin
      chk(req, "rd_data", 32'(rd_data), 32'(first + 8'(i)));
      chk(req, "rd_allowed mid", 32'(rd_allowed), 1);
      rd_en = 1; tick(); rd_en = 0;
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1", "frozen", 32'(frozen), 1);
    chk("R1", "tok_req", 32'(tok_req), 0);
    chk("R1", "flags", {rx_flag, fifo_ctl, irq, rd_allowed}, 0);
    rst_n = 1; tick(); tick();
    // R2 frozen: no request
    chk("R2", "tok_req frozen", 32'(tok_req), 0);

    for (int v = 0; v < 4; v++) begin
      int len = int'(VEC[v][14:8]);
      logic [7:0] first = VEC[v][7:0];
      irq_en = v[0];
      req_endless = 0; req_count = 0;
      pulse_clr();
      chk("R2", "tok_req after unfreeze", 32'(tok_req), 1);
      handshake("R3");
      chk("R3", "frozen after single request", 32'(frozen), 1);
      chk("R3", "pkt_ready", 32'(pkt_ready), 1);
      send_pkt(len, first);
      chk("R5", "rx_flag,fifo_ctl", {rx_flag, fifo_ctl}, 2'b11);
      chk("R5", "irq", 32'(irq), 32'(irq_en));
      pulse_ack();
      chk("R6", "rx_flag after ack", 32'(rx_flag), 0);
      chk("R6", "fifo_ctl after ack", 32'(fifo_ctl), 1);
      chk("R6", "rd_data after ack", 32'(rd_data), 32'(first));
      chk("R5", "irq after ack", 32'(irq), 0);
      drain("R11", len, first);
      chk("R9", "rd_allowed at end", 32'(rd_allowed), 0);
      chk("R9", "fifo_ctl at end", 32'(fifo_ctl), 1);
      pulse_release();
      chk("R7", "flags after release to empty", {rx_flag, fifo_ctl}, 2'b00);
    end

    // R3 counted run of two requests
    irq_en = 0; req_endless = 0; req_count = 8'd1;
    pulse_clr();
    handshake("R3");
    chk("R3", "frozen after 1 of 2", 32'(frozen), 0);
    send_pkt(3, 8'h50);
    handshake("R3");
    chk("R3", "frozen after 2 of 2", 32'(frozen), 1);
    send_pkt(2, 8'h70);
    tick(); tick();
    chk("R3", "no third request", 32'(tok_req), 0);

    // R8 release while rx_flag set
    pulse_release();
    chk("R8", "fifo_ctl", 32'(fifo_ctl), 1);
    chk("R8", "rd_data", 32'(rd_data), 32'h50);

    // R10 endless with every bank full
    req_endless = 1;
    pulse_clr();
    chk("R10", "frozen", 32'(frozen), 0);
    for (int i = 0; i < 5; i++) begin
      chk("R10", "tok_req stalled", 32'(tok_req), 0);
      tick();
    end
    pulse_ack();
    drain("R11", 3, 8'h50);
    pulse_release();
    chk("R7", "flags reload from full bank", {rx_flag, fifo_ctl}, 2'b11);
    chk("R11", "rd_data next bank", 32'(rd_data), 32'h70);
    chk("R10", "tok_req resumes", 32'(tok_req), 1);
    handshake("R4");
    send_pkt(1, 8'hC3);
    chk("R4", "still unfrozen", 32'(frozen), 0);
    chk("R10", "stalled again", 32'(tok_req), 0);
    pulse_ack();
    drain("R11", 2, 8'h70);
    pulse_release();
    chk("R7", "flags on third packet", {rx_flag, fifo_ctl}, 2'b11);
    chk("R11", "rd_data third", 32'(rd_data), 32'hC3);
    pulse_ack();
    pulse_release();
    chk("R4", "request again", 32'(tok_req), 1);
    freeze_set = 1; tick(); freeze_set = 0;
    chk("R2", "tok_req after freeze_set", 32'(tok_req), 0);

    // R1 reset mid-run
    req_endless = 0; req_count = 0;
    pulse_clr();
    handshake("R3");
    send_pkt(1, 8'h01);
    rst_n = 0; #2;
    chk("R1", "flags in reset", {rx_flag, fifo_ctl, rd_allowed, tok_req}, 0);
    chk("R1", "frozen in reset", 32'(frozen), 1);
    rst_n = 1; tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule